// File: doc/BRIEF.md
# Area-Group Lock and Password Controller

This block protects a user memory of 4096 sixteen-bit words. The memory is split into 16 groups of 16 areas, and each area holds 16 words. Each group has three pieces of state: a 32-bit password, a 16-bit vector of per-area read locks and a 16-bit vector of per-area write locks. The block runs four changing commands: set a new group password, change read locks, change write locks, and set write locks with no password. It also answers two permission queries. A read query covers a word range. A write query covers a word range and also weighs the bank lock bits, the tag state and a permalock hit supplied from outside.

Commands arrive already decoded from the air interface, as one valid/ready transfer. Every accepted command produces exactly one response transfer that carries a status code and a flag telling the protocol engine to drop back to the arbitrate state. The response register holds one entry. `cmd_ready` is high while that register is empty or is being drained in the same cycle, so a stalled response stops new commands. A response stays stable until `rsp_ready` takes it. Tag state, bank lock bits and the permalock hit are plain inputs and are sampled together with the command.

Top module: `ag_lock_ctrl`

## Requirements
- R1: A word address is {group[11:8], area[7:4], word[3:0]}, and a range covers the areas from addr[11:4] to (addr+cnt-1)[11:4]. A range that ends past word 4095 returns OVERRUN (2). A query with cnt = 0 returns OK (0).
- R2: The read-lock op (1) and the write-lock op (2) change lock bits only when cmd_pwd equals the target group's stored password. For every area i with mask bit i = 1, the lock becomes action bit i. Areas with mask bit 0 keep their lock. A wrong password returns PWDFAIL (4) and changes nothing.
- R3: The password op (0) needs the correct current password. It then returns OK, and the new password applies to the very next command. A wrong password returns NOREPLY (5) with rsp_to_arb = 1 and leaves the password unchanged. rsp_to_arb is 1 for no other outcome.
- R4: After the synchronous reset, all passwords are zero, all read and write locks are clear and no response is pending.
- R5: The password-free op (3) sets the write lock of each area whose action bit is 1. It never clears a lock and needs no password.
- R6: The read query (op 4) returns LOCKED (1) if any area in the range is read-locked, and OK otherwise. Write locks, bank lock bits and the permalock hit do not affect it.
- R7: The write query (op 5) returns LOCKED if any area in the range is write-locked or permalock_hit = 1, whatever the bank bits and state. Otherwise the bank bits decide: 00 and 01 give OK, 10 gives OK only in the secured state, and 11 always gives LOCKED.
- R8: The group field is 5 bits. A changing op whose group MSB is 1 returns BADPTR (3) and changes nothing.
- R9: An invalid handle, a tag state other than open (2) or secured (3), or an undefined op (6, 7) returns IGNORED (6) and changes nothing.
- R10: The response appears in the cycle after acceptance. It holds its value while rsp_ready = 0, and cmd_ready = 0 during that time.
- R11: Queries leave all passwords and locks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command transfer valid |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Operation code |
| cmd_handle_ok | input | 1 | Handle matched |
| cmd_group | input | 5 | Target group, MSB must be 0 |
| cmd_pwd | input | 32 | Current password presented |
| cmd_new_pwd | input | 32 | Replacement password |
| cmd_mask | input | 16 | Per-area change mask |
| cmd_action | input | 16 | Per-area lock value |
| cmd_addr | input | 12 | First word of a query range |
| cmd_cnt | input | 8 | Word count of a query |
| tag_state | input | 2 | 0 ready, 1 arbitrate, 2 open, 3 secured |
| bank_lock | input | 2 | Bank lock bits of user memory |
| permalock_hit | input | 1 | Some word in the query range is permalocked |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 3 | Status code |
| rsp_to_arb | output | 1 | Return to the arbitrate state |

## Verification
The assertions take three things for granted. First, tag_state, bank_lock and permalock_hit are steady during the cycle a command is accepted. Second, permalock_hit describes the same word range as cmd_addr and cmd_cnt. Third, cmd_cnt is at most 255. The stimulus drives every field at the falling edge, together with cmd_valid, and holds those fields until acceptance. It computes permalock_hit for the range it is querying, and it keeps every count inside the 8-bit field.

// File: rtl/ag_lock_pkg.sv
package ag_lock_pkg;
  typedef enum logic [2:0] {
    OP_SETPWD = 3'd0,
    OP_RDLOCK = 3'd1,
    OP_WRLOCK = 3'd2,
    OP_WRSET  = 3'd3,
    OP_CHKRD  = 3'd4,
    OP_CHKWR  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_LOCKED  = 3'd1,
    ST_OVERRUN = 3'd2,
    ST_BADPTR  = 3'd3,
    ST_PWDFAIL = 3'd4,
    ST_NOREPLY = 3'd5,
    ST_IGNORED = 3'd6
  } st_e;

  typedef enum logic [1:0] {
    TS_READY   = 2'd0,
    TS_ARB     = 2'd1,
    TS_OPEN    = 2'd2,
    TS_SECURED = 2'd3
  } ts_e;
endpackage

// File: rtl/ag_range.sv
module ag_range #(
  parameter int ADDR_W = 12,
  parameter int WW     = 4,
  parameter int CNT_W  = 8,
  parameter int NTOT   = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [NTOT-1:0]   in_rng,
  output logic              over,
  output logic              any
);
  localparam int IW = ADDR_W - WW;

  logic [ADDR_W:0]   last_w;
  logic [IW-1:0]     first_a;
  logic [IW-1:0]     last_a;

  assign last_w  = {1'b0, addr} + {{(ADDR_W+1-CNT_W){1'b0}}, cnt} - {{ADDR_W{1'b0}}, 1'b1};
  assign any     = (cnt != '0);
  assign over    = any && last_w[ADDR_W];
  assign first_a = addr[ADDR_W-1:WW];
  assign last_a  = last_w[ADDR_W-1:WW];

  for (genvar k = 0; k < NTOT; k++) begin : g_area
    assign in_rng[k] = any && !over && (IW'(k) >= first_a) && (IW'(k) <= last_a);
  end
endmodule

// File: rtl/ag_lock_store.sv
module ag_lock_store
  import ag_lock_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int NAREA = 16,
  parameter int PWD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [2:0]              upd_op,
  input  logic [$clog2(NGRP)-1:0] upd_grp,
  input  logic [NAREA-1:0]        mask,
  input  logic [NAREA-1:0]        action,
  input  logic [PWD_W-1:0]        new_pwd,
  output logic [NGRP*PWD_W-1:0]   pwd_flat,
  output logic [NGRP*NAREA-1:0]   rd_vec,
  output logic [NGRP*NAREA-1:0]   wr_vec
);
  localparam int GW = $clog2(NGRP);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [PWD_W-1:0] pwd_q;
    logic [NAREA-1:0] rd_q;
    logic [NAREA-1:0] wr_q;
    logic             hit;

    assign hit = upd_en && (upd_grp == GW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pwd_q <= '0;
        rd_q  <= '0;
        wr_q  <= '0;
      end else if (hit) begin
        case (op_e'(upd_op))
          OP_SETPWD: pwd_q <= new_pwd;
          OP_RDLOCK: rd_q  <= (rd_q & ~mask) | (mask & action);
          OP_WRLOCK: wr_q  <= (wr_q & ~mask) | (mask & action);
          OP_WRSET:  wr_q  <= wr_q | action;
          default:   ;
        endcase
      end
    end

    assign pwd_flat[g*PWD_W +: PWD_W] = pwd_q;
    assign rd_vec[g*NAREA +: NAREA]   = rd_q;
    assign wr_vec[g*NAREA +: NAREA]   = wr_q;
  end
endmodule

// File: rtl/ag_perm_eval.sv
module ag_perm_eval
  import ag_lock_pkg::*;
#(
  parameter int NTOT = 256
) (
  input  logic [NTOT-1:0] in_rng,
  input  logic            over,
  input  logic            any,
  input  logic [NTOT-1:0] rd_vec,
  input  logic [NTOT-1:0] wr_vec,
  input  logic [1:0]      bank_lock,
  input  logic            secured,
  input  logic            permalock_hit,
  output logic [2:0]      rd_st,
  output logic [2:0]      wr_st
);
  logic rd_hit;
  logic wr_hit;
  logic bank_block;

  assign rd_hit     = |(in_rng & rd_vec);
  assign wr_hit     = |(in_rng & wr_vec) || (permalock_hit && any);
  assign bank_block = any && ((bank_lock == 2'b11) || (bank_lock == 2'b10 && !secured));

  always_comb begin
    if (over)        rd_st = ST_OVERRUN;
    else if (rd_hit) rd_st = ST_LOCKED;
    else             rd_st = ST_OK;

    if (over)            wr_st = ST_OVERRUN;
    else if (wr_hit)     wr_st = ST_LOCKED;
    else if (bank_block) wr_st = ST_LOCKED;
    else                 wr_st = ST_OK;
  end
endmodule

// File: rtl/ag_lock_ctrl.sv
module ag_lock_ctrl
  import ag_lock_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int NAREA = 16,
  parameter int NWORD = 16,
  parameter int PWD_W = 32,
  parameter int CNT_W = 8
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  cmd_valid,
  output logic                                                  cmd_ready,
  input  logic [2:0]                                            cmd_op,
  input  logic                                                  cmd_handle_ok,
  input  logic [$clog2(NGRP):0]                                 cmd_group,
  input  logic [PWD_W-1:0]                                      cmd_pwd,
  input  logic [PWD_W-1:0]                                      cmd_new_pwd,
  input  logic [NAREA-1:0]                                      cmd_mask,
  input  logic [NAREA-1:0]                                      cmd_action,
  input  logic [$clog2(NGRP)+$clog2(NAREA)+$clog2(NWORD)-1:0]   cmd_addr,
  input  logic [CNT_W-1:0]                                      cmd_cnt,
  input  logic [1:0]                                            tag_state,
  input  logic [1:0]                                            bank_lock,
  input  logic                                                  permalock_hit,
  output logic                                                  rsp_valid,
  input  logic                                                  rsp_ready,
  output logic [2:0]                                            rsp_status,
  output logic                                                  rsp_to_arb
);
  localparam int GW     = $clog2(NGRP);
  localparam int WW     = $clog2(NWORD);
  localparam int ADDR_W = GW + $clog2(NAREA) + WW;
  localparam int NTOT   = NGRP * NAREA;

  logic                  acc;
  logic                  state_ok;
  logic                  grp_ok;
  logic [GW-1:0]         grp;
  logic [PWD_W-1:0]      sel_pwd;
  logic                  pwd_match;
  logic [NGRP*PWD_W-1:0] pwd_flat;
  logic [NTOT-1:0]       rd_vec;
  logic [NTOT-1:0]       wr_vec;
  logic [NTOT-1:0]       in_rng;
  logic                  rng_over;
  logic                  rng_any;
  logic [2:0]            rd_st;
  logic [2:0]            wr_st;
  logic [2:0]            st_n;
  logic                  arb_n;
  logic                  upd_en;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign state_ok  = (tag_state == TS_OPEN) || (tag_state == TS_SECURED);
  assign grp_ok    = !cmd_group[GW];
  assign grp       = cmd_group[GW-1:0];
  assign sel_pwd   = pwd_flat[grp*PWD_W +: PWD_W];
  assign pwd_match = (sel_pwd == cmd_pwd);

  ag_range #(.ADDR_W(ADDR_W), .WW(WW), .CNT_W(CNT_W), .NTOT(NTOT)) u_range (
    .addr   (cmd_addr),
    .cnt    (cmd_cnt),
    .in_rng (in_rng),
    .over   (rng_over),
    .any    (rng_any)
  );

  ag_perm_eval #(.NTOT(NTOT)) u_eval (
    .in_rng        (in_rng),
    .over          (rng_over),
    .any           (rng_any),
    .rd_vec        (rd_vec),
    .wr_vec        (wr_vec),
    .bank_lock     (bank_lock),
    .secured       (tag_state == TS_SECURED),
    .permalock_hit (permalock_hit),
    .rd_st         (rd_st),
    .wr_st         (wr_st)
  );

  always_comb begin
    st_n   = ST_OK;
    arb_n  = 1'b0;
    upd_en = 1'b0;
    if (!cmd_handle_ok || !state_ok) begin
      st_n = ST_IGNORED;
    end else begin
      case (op_e'(cmd_op))
        OP_SETPWD, OP_RDLOCK, OP_WRLOCK, OP_WRSET: begin
          if (!grp_ok) begin
            st_n = ST_BADPTR;
          end else if (op_e'(cmd_op) != OP_WRSET && !pwd_match) begin
            if (op_e'(cmd_op) == OP_SETPWD) begin
              st_n  = ST_NOREPLY;
              arb_n = 1'b1;
            end else begin
              st_n = ST_PWDFAIL;
            end
          end else begin
            upd_en = 1'b1;
          end
        end
        OP_CHKRD: st_n = rd_st;
        OP_CHKWR: st_n = wr_st;
        default:  st_n = ST_IGNORED;
      endcase
    end
  end

  ag_lock_store #(.NGRP(NGRP), .NAREA(NAREA), .PWD_W(PWD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (acc && upd_en),
    .upd_op   (cmd_op),
    .upd_grp  (grp),
    .mask     (cmd_mask),
    .action   (cmd_action),
    .new_pwd  (cmd_new_pwd),
    .pwd_flat (pwd_flat),
    .rd_vec   (rd_vec),
    .wr_vec   (wr_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_to_arb <= 1'b0;
    end else if (acc) begin
      rsp_valid  <= 1'b1;
      rsp_status <= st_n;
      rsp_to_arb <= arb_n;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ag_lock_chk.sv
module ag_lock_chk #(
  parameter int NTOT  = 256,
  parameter int PW_T  = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc,
  input logic [2:0]      cmd_op,
  input logic            cmd_handle_ok,
  input logic [1:0]      tag_state,
  input logic [1:0]      bank_lock,
  input logic            rng_over,
  input logic            rng_any,
  input logic            cmd_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_status,
  input logic            rsp_to_arb,
  input logic [NTOT-1:0] rd_vec,
  input logic [NTOT-1:0] wr_vec,
  input logic [PW_T-1:0] pwd_flat
);
  logic live;
  assign live = cmd_handle_ok && tag_state[1];

  AST_WRSET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd3 |=> (($past(wr_vec) & ~wr_vec) == '0)); // R5

  AST_BAD_HANDLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_handle_ok |=> $stable(rd_vec) && $stable(wr_vec) && $stable(pwd_flat)
      && rsp_status == 3'd6); // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_to_arb)); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready); // R10

  AST_BANK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && live && cmd_op == 3'd5 && bank_lock == 2'b11 && rng_any && !rng_over
      |=> rsp_status == 3'd1); // R7

  AST_ARB_ONLY_NOREPLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_to_arb |-> rsp_status == 3'd5); // R3

  AST_QUERY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 3'd4 || cmd_op == 3'd5)
      |=> $stable(rd_vec) && $stable(wr_vec) && $stable(pwd_flat)); // R11
endmodule

bind ag_lock_ctrl ag_lock_chk #(.NTOT(NTOT), .PW_T(NGRP*PWD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc           (acc),
  .cmd_op        (cmd_op),
  .cmd_handle_ok (cmd_handle_ok),
  .tag_state     (tag_state),
  .bank_lock     (bank_lock),
  .rng_over      (rng_over),
  .rng_any       (rng_any),
  .cmd_ready     (cmd_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_status    (rsp_status),
  .rsp_to_arb    (rsp_to_arb),
  .rd_vec        (rd_vec),
  .wr_vec        (wr_vec),
  .pwd_flat      (pwd_flat)
);

// File: tb/sim_ag_lock_ctrl.sv
module sim_ag_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic        cmd_handle_ok = 1'b1;
  logic [4:0]  cmd_group = '0;
  logic [31:0] cmd_pwd = '0;
  logic [31:0] cmd_new_pwd = '0;
  logic [15:0] cmd_mask = '0;
  logic [15:0] cmd_action = '0;
  logic [11:0] cmd_addr = '0;
  logic [7:0]  cmd_cnt = '0;
  logic [1:0]  tag_state = 2'd2;
  logic [1:0]  bank_lock = 2'd0;
  logic        permalock_hit = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_status;
  logic        rsp_to_arb;

  always #2 clk = ~clk;

  ag_lock_ctrl u0 (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;
  int r_st;
  int r_arb;

  logic [31:0] m_pwd [16];
  logic [15:0] m_rd  [16];
  logic [15:0] m_wr  [16];

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int g = 0; g < 16; g++) begin
      m_pwd[g] = '0; m_rd[g] = '0; m_wr[g] = '0;
    end
  endtask

  task automatic send(input int op, input bit hok, input int grp, input logic [31:0] pw,
                      input logic [31:0] np, input logic [15:0] m, input logic [15:0] a,
                      input int addr, input int cnt, input int ts, input int bl, input bit ph);
    @(negedge clk);
    cmd_op = op[2:0]; cmd_handle_ok = hok; cmd_group = grp[4:0];
    cmd_pwd = pw; cmd_new_pwd = np; cmd_mask = m; cmd_action = a;
    cmd_addr = addr[11:0]; cmd_cnt = cnt[7:0]; tag_state = ts[1:0];
    bank_lock = bl[1:0]; permalock_hit = ph; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_st = int'(rsp_status);
    r_arb = int'(rsp_to_arb);
  endtask

  function automatic int exp_rd(input int addr, input int cnt, input int ts);
    int e;
    if (ts < 2) return 6;
    if (cnt == 0) return 0;
    e = addr + cnt - 1;
    if (e > 4095) return 2;
    for (int w = addr / 16; w <= e / 16; w++)
      if (m_rd[w / 16][w % 16]) return 1;
    return 0;
  endfunction

  function automatic int exp_wr(input int addr, input int cnt, input int ts, input int bl, input bit ph);
    int e;
    if (ts < 2) return 6;
    if (cnt == 0) return 0;
    e = addr + cnt - 1;
    if (e > 4095) return 2;
    if (ph) return 1;
    for (int w = addr / 16; w <= e / 16; w++)
      if (m_wr[w / 16][w % 16]) return 1;
    if (bl == 3) return 1;
    if (bl == 2 && ts != 3) return 1;
    return 0;
  endfunction

  task automatic sweep(input int ts, input int bl);
    for (int a = 0; a < 256; a++) begin
      send(4, 1, 0, 0, 0, 0, 0, a * 16, 16, ts, bl, 0);
      chk("R6 area read query", r_st, exp_rd(a * 16, 16, ts));
      send(5, 1, 0, 0, 0, 0, 0, a * 16, 16, ts, bl, 0);
      chk("R7 area write query", r_st, exp_wr(a * 16, 16, ts, bl, 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] np;
    logic [15:0] mk;
    logic [15:0] ac;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R10 cmd_ready idle", int'(cmd_ready), 1);
    rst_n = 1'b1;

    // R4: whole memory unlocked, zero passwords
    sweep(2, 0);
    send(2, 1, 5, 32'h0, 0, 16'h0000, 16'h0000, 0, 0, 2, 0, 0);
    chk("R4 zero password accepted", r_st, 0);

    // R7: bank lock / state / permalock table on unlocked area
    for (int bl = 0; bl < 4; bl++)
      for (int ts = 0; ts < 4; ts++)
        for (int ph = 0; ph < 2; ph++) begin
          send(5, 1, 0, 0, 0, 0, 0, 12'h100, 4, ts, bl, ph[0]);
          chk("R7 precedence table", r_st, exp_wr(12'h100, 4, ts, bl, ph[0]));
          send(4, 1, 0, 0, 0, 0, 0, 12'h100, 4, ts, bl, ph[0]);
          chk("R6 read ignores bank and permalock", r_st, exp_rd(12'h100, 4, ts));
        end

    // R1 boundaries
    send(4, 1, 0, 0, 0, 0, 0, 4095, 2, 2, 0, 0);
    chk("R1 overrun", r_st, 2);
    send(5, 1, 0, 0, 0, 0, 0, 4095, 1, 2, 0, 0);
    chk("R1 last word", r_st, 0);
    send(5, 1, 0, 0, 0, 0, 0, 0, 0, 2, 3, 1);
    chk("R1 zero count granted", r_st, 0);

    // R3 password changes
    for (int g = 0; g < 16; g++) begin
      np = 32'hA5A5_0000 | (g * 257 + 1);
      send(0, 1, g, 32'h1, np, 0, 0, 0, 0, 2, 0, 0);
      chk("R3 wrong password status", r_st, 5);
      chk("R3 wrong password to_arb", r_arb, 1);
      send(0, 1, g, m_pwd[g], np, 0, 0, 0, 0, 3, 0, 0);
      chk("R3 correct password", r_st, 0);
      chk("R3 no arb on success", r_arb, 0);
      m_pwd[g] = np;
      send(1, 1, g, 32'h0, 0, 16'hFFFF, 16'hFFFF, 0, 0, 2, 0, 0);
      chk("R3 old password refused", r_st, 4);
    end

    // R2 lock changes with mask/action, R8 bad pointer, R9 ignore
    for (int g = 0; g < 16; g++) begin
      mk = 16'h5A5A ^ (16'h0111 * g);
      ac = 16'hF0F0 ^ g[15:0];
      send(1, 1, g, m_pwd[g], 0, mk, ac, 0, 0, 2, 0, 0);
      chk("R2 read lock change", r_st, 0);
      m_rd[g] = (m_rd[g] & ~mk) | (mk & ac);
      mk = 16'h3C3C ^ (g[15:0] << 4);
      ac = 16'hAAAA ^ g[15:0];
      send(2, 1, g, m_pwd[g], 0, mk, ac, 0, 0, 3, 0, 0);
      chk("R2 write lock change", r_st, 0);
      m_wr[g] = (m_wr[g] & ~mk) | (mk & ac);
      send(2, 1, g, m_pwd[g] + 1, 0, 16'hFFFF, 16'h0000, 0, 0, 2, 0, 0);
      chk("R2 wrong password", r_st, 4);
      send(1, 1, 16 + g, m_pwd[g], 0, 16'hFFFF, ~m_rd[g], 0, 0, 2, 0, 0);
      chk("R8 group msb set", r_st, 3);
      send(0, 1, 16 + g, m_pwd[g], 32'h0, 0, 0, 0, 0, 2, 0, 0);
      chk("R8 password bad pointer", r_st, 3);
      send(2, 0, g, m_pwd[g], 0, 16'hFFFF, ~m_wr[g], 0, 0, 2, 0, 0);
      chk("R9 invalid handle", r_st, 6);
      send(1, 1, g, m_pwd[g], 0, 16'hFFFF, ~m_rd[g], 0, 0, 1, 0, 0);
      chk("R9 arbitrate state", r_st, 6);
      send(7, 1, g, m_pwd[g], 0, 16'hFFFF, 16'hFFFF, 0, 0, 2, 0, 0);
      chk("R9 undefined op", r_st, 6);
    end
    sweep(2, 0);
    sweep(3, 2);

    // R5 password-free set never clears; R2 mask zero keeps
    for (int g = 0; g < 16; g++) begin
      ac = 16'h8421 << (g % 4);
      send(3, 1, g, 32'hDEAD_BEEF, 0, 16'h0000, ac, 0, 0, 2, 0, 0);
      chk("R5 set without password", r_st, 0);
      m_wr[g] = m_wr[g] | ac;
      send(1, 1, g, m_pwd[g], 0, 16'h0000, 16'hFFFF, 0, 0, 2, 0, 0);
      chk("R2 zero mask", r_st, 0);
    end
    sweep(2, 1);

    // R1 ranges crossing area boundaries
    for (int k = 0; k < 255; k++) begin
      send(4, 1, 0, 0, 0, 0, 0, k * 16 + 15, 2, 2, 0, 0);
      chk("R1 straddle read", r_st, exp_rd(k * 16 + 15, 2, 2));
      send(5, 1, 0, 0, 0, 0, 0, k * 16 + 15, 2, 3, 2, 0);
      chk("R1 straddle write", r_st, exp_wr(k * 16 + 15, 2, 3, 2, 0));
    end
    send(4, 1, 0, 0, 0, 0, 0, 100, 255, 2, 0, 0);
    chk("R1 long range", r_st, exp_rd(100, 255, 2));

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_op = 3'd5; cmd_handle_ok = 1'b1; cmd_addr = 12'd4095; cmd_cnt = 8'd9;
    tag_state = 2'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 response valid", int'(rsp_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held valid", int'(rsp_valid), 1);
      chk("R10 held status", int'(rsp_status), 2);
      chk("R10 ready low", int'(cmd_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", int'(rsp_valid), 0);

    // R4 reset again clears state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    sweep(2, 0);
    send(1, 1, 9, 32'h0, 0, 16'h0001, 16'h0001, 0, 0, 2, 0, 0);
    chk("R4 password zero after reset", r_st, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule